// File: doc/BRIEF.md
# Interrupt Entry and Exit Sequencer

This block decides when the processor leaves its current context for an interrupt handler and how it leaves a handler again. Each cycle it compares the most urgent pending interrupt with the current execution priority. The current execution priority is either thread level or the priority of the handler now running. From that comparison it steps through the entry and return sequences. The register save and restore, the bus traffic, the pending bookkeeping and the pipeline are outside the block. Each of them appears only as a request output and a completion input.

On entry the block raises a stacking request and issues a vector fetch in the same cycle. A handler starts only after three things: stacking has finished, the vector has been fetched, and the first handler instruction reports that it has reached execute. A more urgent interrupt that arrives before that point takes over the pending entry. It gets a fresh vector fetch, and stacking runs on untouched. When a handler finishes, a pending interrupt that outranks the context being returned to is chained straight in without restoring state. A restore already under way is dropped if such an interrupt arrives while it runs. An eight-level stack of active priorities tracks nesting.

Top module: `exc_sequencer`

## Requirements
- R1: A pending interrupt starts an entry only if its priority value is strictly smaller than the execution priority. A smaller value is more urgent, an equal value never pre-empts, and thread level reads as 2**PRIO_W (16 by default), below every interrupt.
- R2: In the cycle after an entry is accepted, stack_req is high and vec_req is a one-cycle pulse, with vec_num carrying the accepted interrupt number.
- R3: handler_start is a one-cycle pulse in the cycle after first_exec is sampled. It needs stacking to be complete (or not needed) and vec_done to have been seen for the latest fetch in some earlier cycle. After it, exec_prio equals the new handler's priority.
- R4: At every fetch issue, vec_sys is registered as 1 when vtab_base >= CODE_LIMIT (default 32'h2000_0000) and as 0 otherwise.
- R5: From the cycle an entry is accepted until its handler starts, a pending interrupt strictly more urgent than the chosen one replaces it. A new vec_req pulse is issued with the new number, and stack_req stays as it was.
- R6: An interrupt arriving in the same cycle that first_exec completes an entry does not replace it. The handler starts, and the arrival is then treated as a normal pre-emption in the next cycle.
- R7: On handler_done, if a pending interrupt is strictly more urgent than the context being returned to, no unstack or stacking is requested. A vec_req is issued, and once the new handler starts, nest_depth is unchanged.
- R8: Otherwise handler_done raises unstack_req until unstack_done. Then ret_to_thread pulses if no handler remains, or ret_to_handler pulses if one does, and exec_prio shows the returned-to context.
- R9: During unstacking, a pending interrupt strictly more urgent than the context being returned to drops unstack_req in the next cycle and issues a vec_req. No stacking is requested, and it is completed as a tail-chain.
- R10: nest_depth rises by one at each handler start and falls by one at each handler_done, up to DEPTH (8). A start with the stack full leaves nest_depth at DEPTH and sets ovf_err, which stays set until reset.
- R11: After reset, all request and strobe outputs are low, exec_prio is thread level (16), nest_depth is 0 and ovf_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_valid | input | 1 | An interrupt is pending |
| pend_prio | input | PRIO_W | Priority of the most urgent pending interrupt |
| pend_num | input | NUM_W | Number of that interrupt |
| vtab_base | input | ADDR_W | Vector table base address |
| stack_done | input | 1 | State save finished |
| vec_done | input | 1 | Vector fetch finished |
| first_exec | input | 1 | First handler instruction in execute |
| handler_done | input | 1 | Running handler requests return |
| unstack_done | input | 1 | State restore finished |
| stack_req | output | 1 | State save requested |
| unstack_req | output | 1 | State restore requested |
| vec_req | output | 1 | Vector fetch issue pulse |
| vec_num | output | NUM_W | Interrupt number to fetch |
| vec_sys | output | 1 | Fetch uses the system path (1) or the code path (0) |
| handler_start | output | 1 | Handler begins |
| ret_to_thread | output | 1 | Return to thread completed |
| ret_to_handler | output | 1 | Return to an interrupted handler completed |
| exec_prio | output | PRIO_W+1 | Current execution priority |
| nest_depth | output | $clog2(DEPTH+1) | Active handler count |
| ovf_err | output | 1 | Sticky nesting overflow |

## Verification
The sharpest collision is a more urgent interrupt arriving in the very cycle that first_exec closes an entry. In that cycle, late-arrival replacement and handler start compete. The bench holds first_exec and the new request together in one cycle. It then expects handler_start with the old priority and no new fetch in that cycle, followed one cycle later by a stacking request and a fetch for the newcomer. The same pattern covers handler_done against a pending interrupt: tail-chain and unstack compete there, and the bench provokes it on both sides of the priority comparison.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_STACKING  = 3'd1,
    S_VECWAIT   = 3'd2,
    S_HANDLER   = 3'd3,
    S_UNSTACKING = 3'd4,
    S_TAILCHAIN = 3'd5
  } seq_state_e;
endpackage

// File: rtl/exc_prio_stack.sv
module exc_prio_stack #(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [PRIO_W:0]   exec_prio,
  output logic [PRIO_W:0]   ret_prio,
  output logic [CW-1:0]     depth,
  output logic              ovf
);
  localparam logic [PRIO_W:0] THREAD_P = {1'b1, {PRIO_W{1'b0}}};

  logic [PRIO_W-1:0] lvl [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (depth == CW'(DEPTH)) begin
        ovf <= 1'b1;
      end else begin
        lvl[AW'(depth)] <= push_prio;
        depth <= depth + CW'(1);
      end
    end else if (pop && depth != '0) begin
      depth <= depth - CW'(1);
    end
  end

  always_comb begin
    exec_prio = THREAD_P;
    ret_prio  = THREAD_P;
    if (depth != '0) exec_prio = {1'b0, lvl[AW'(depth - CW'(1))]};
    if (depth > CW'(1)) ret_prio = {1'b0, lvl[AW'(depth - CW'(2))]};
  end
endmodule

// File: rtl/exc_seq_arb.sv
module exc_seq_arb #(
  parameter int PRIO_W = 4
) (
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W:0]   exec_prio,
  input  logic [PRIO_W:0]   ret_prio,
  input  logic [PRIO_W-1:0] sel_prio,
  output logic              preempt_ev,
  output logic              late_ev,
  output logic              chain_ev
);
  // strictly more urgent: smaller value wins, ties lose
  function automatic logic beats(input logic [PRIO_W-1:0] cand,
                                 input logic [PRIO_W:0] level);
    return {1'b0, cand} < level;
  endfunction

  assign preempt_ev = pend_valid && beats(pend_prio, exec_prio);
  assign late_ev    = pend_valid && beats(pend_prio, {1'b0, sel_prio});
  assign chain_ev   = pend_valid && beats(pend_prio, ret_prio);
endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch #(
  parameter int NUM_W  = 6,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CODE_LIMIT = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [NUM_W-1:0]  issue_num,
  input  logic [ADDR_W-1:0] vtab_base,
  input  logic              vec_done,
  output logic              vec_req,
  output logic [NUM_W-1:0]  vec_num,
  output logic              vec_sys,
  output logic              vec_ok
);
  function automatic logic on_sys_path(input logic [ADDR_W-1:0] base);
    return base >= CODE_LIMIT;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_req <= 1'b0;
      vec_num <= '0;
      vec_sys <= 1'b0;
      vec_ok  <= 1'b0;
    end else begin
      vec_req <= issue;
      if (issue) begin
        vec_num <= issue_num;
        vec_sys <= on_sys_path(vtab_base);
        vec_ok  <= 1'b0;
      end else if (vec_done) begin
        vec_ok  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_seq_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int NUM_W  = 6,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter logic [ADDR_W-1:0] CODE_LIMIT = 32'h2000_0000,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [NUM_W-1:0]  pend_num,
  input  logic [ADDR_W-1:0] vtab_base,
  input  logic              stack_done,
  input  logic              vec_done,
  input  logic              first_exec,
  input  logic              handler_done,
  input  logic              unstack_done,
  output logic              stack_req,
  output logic              unstack_req,
  output logic              vec_req,
  output logic [NUM_W-1:0]  vec_num,
  output logic              vec_sys,
  output logic              handler_start,
  output logic              ret_to_thread,
  output logic              ret_to_handler,
  output logic [PRIO_W:0]   exec_prio,
  output logic [CW-1:0]     nest_depth,
  output logic              ovf_err
);
  seq_state_e st_q, st_d;
  logic [PRIO_W-1:0] sel_prio_q;
  logic [PRIO_W:0]   ret_prio;
  logic issue, push, pop, vec_ok;
  logic preempt_ev, late_ev, chain_ev;
  logic hs_d, rt_d, rh_d;

  exc_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .push_prio(sel_prio_q),
    .exec_prio(exec_prio), .ret_prio(ret_prio), .depth(nest_depth), .ovf(ovf_err)
  );

  exc_seq_arb #(.PRIO_W(PRIO_W)) u_arb (
    .pend_valid(pend_valid), .pend_prio(pend_prio), .exec_prio(exec_prio),
    .ret_prio(ret_prio), .sel_prio(sel_prio_q),
    .preempt_ev(preempt_ev), .late_ev(late_ev), .chain_ev(chain_ev)
  );

  exc_vec_fetch #(.NUM_W(NUM_W), .ADDR_W(ADDR_W), .CODE_LIMIT(CODE_LIMIT)) u_fetch (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_num(pend_num),
    .vtab_base(vtab_base), .vec_done(vec_done), .vec_req(vec_req),
    .vec_num(vec_num), .vec_sys(vec_sys), .vec_ok(vec_ok)
  );

  always_comb begin
    st_d  = st_q;
    issue = 1'b0;
    push  = 1'b0;
    pop   = 1'b0;
    hs_d  = 1'b0;
    rt_d  = 1'b0;
    rh_d  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (preempt_ev) begin
          issue = 1'b1;
          st_d  = S_STACKING;
        end
      end
      S_HANDLER: begin
        if (handler_done) begin
          pop = 1'b1;
          if (chain_ev) begin
            issue = 1'b1;
            st_d  = S_TAILCHAIN;
          end else begin
            st_d  = S_UNSTACKING;
          end
        end else if (preempt_ev) begin
          issue = 1'b1;
          st_d  = S_STACKING;
        end
      end
      S_STACKING: begin
        if (late_ev) issue = 1'b1;
        if (stack_done) st_d = S_VECWAIT;
      end
      S_VECWAIT, S_TAILCHAIN: begin
        if (first_exec && vec_ok) begin
          push = 1'b1;
          hs_d = 1'b1;
          st_d = S_HANDLER;
        end else if (late_ev) begin
          issue = 1'b1;
        end
      end
      S_UNSTACKING: begin
        if (unstack_done) begin
          if (nest_depth == '0) begin
            rt_d = 1'b1;
            st_d = S_IDLE;
          end else begin
            rh_d = 1'b1;
            st_d = S_HANDLER;
          end
        end else if (preempt_ev) begin
          issue = 1'b1;
          st_d  = S_TAILCHAIN;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q           <= S_IDLE;
      sel_prio_q     <= '0;
      handler_start  <= 1'b0;
      ret_to_thread  <= 1'b0;
      ret_to_handler <= 1'b0;
    end else begin
      st_q           <= st_d;
      handler_start  <= hs_d;
      ret_to_thread  <= rt_d;
      ret_to_handler <= rh_d;
      if (issue) sel_prio_q <= pend_prio;
    end
  end

  assign stack_req   = (st_q == S_STACKING);
  assign unstack_req = (st_q == S_UNSTACKING);
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stack_req,
  input logic            unstack_req,
  input logic            vec_req,
  input logic            vec_ok,
  input logic            first_exec,
  input logic            handler_done,
  input logic            handler_start,
  input logic            ret_to_thread,
  input logic            ret_to_handler,
  input logic [PRIO_W:0] exec_prio,
  input logic [CW-1:0]   nest_depth,
  input logic            ovf_err
);
  localparam logic [PRIO_W:0] THREAD_P = {1'b1, {PRIO_W{1'b0}}};

  // R2
  entry_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stack_req) |-> vec_req);

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handler_start |-> ($past(first_exec) && $past(vec_ok)));

  // R7
  chain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && $past(handler_done)) |-> (!stack_req && !unstack_req));

  // R8
  thread_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_to_thread |-> (nest_depth == '0 && exec_prio == THREAD_P));

  // R9
  abandon_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(unstack_req) && !ret_to_thread && !ret_to_handler) |-> vec_req);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_err) |-> ovf_err);

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= CW'(DEPTH));
endmodule

bind exc_sequencer exc_seq_chk #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .stack_req(stack_req), .unstack_req(unstack_req),
  .vec_req(vec_req), .vec_ok(vec_ok), .first_exec(first_exec),
  .handler_done(handler_done), .handler_start(handler_start),
  .ret_to_thread(ret_to_thread), .ret_to_handler(ret_to_handler),
  .exec_prio(exec_prio), .nest_depth(nest_depth), .ovf_err(ovf_err)
);

// File: tb/exc_sequencer_tb_top.sv
module exc_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pend_valid = 1'b0;
  logic [3:0] pend_prio = '0;
  logic [5:0] pend_num = '0;
  logic [31:0] vtab_base = '0;
  logic stack_done = 1'b0, vec_done = 1'b0, first_exec = 1'b0;
  logic handler_done = 1'b0, unstack_done = 1'b0;
  logic stack_req, unstack_req, vec_req, vec_sys, handler_start;
  logic ret_to_thread, ret_to_handler, ovf_err;
  logic [5:0] vec_num;
  logic [4:0] exec_prio;
  logic [3:0] nest_depth;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  exc_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_prio(pend_prio),
    .pend_num(pend_num), .vtab_base(vtab_base), .stack_done(stack_done),
    .vec_done(vec_done), .first_exec(first_exec), .handler_done(handler_done),
    .unstack_done(unstack_done), .stack_req(stack_req), .unstack_req(unstack_req),
    .vec_req(vec_req), .vec_num(vec_num), .vec_sys(vec_sys),
    .handler_start(handler_start), .ret_to_thread(ret_to_thread),
    .ret_to_handler(ret_to_handler), .exec_prio(exec_prio),
    .nest_depth(nest_depth), .ovf_err(ovf_err)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pend_valid = 1'b0; stack_done = 1'b0; vec_done = 1'b0;
    first_exec = 1'b0; handler_done = 1'b0; unstack_done = 1'b0;
    vtab_base = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic raise(input int p, input int n);
    pend_valid = 1'b1;
    pend_prio = 4'(p);
    pend_num = 6'(n);
  endtask

  task automatic finish_entry();
    vec_done = 1'b1; step(); vec_done = 1'b0;
    stack_done = 1'b1; step(); stack_done = 1'b0;
    first_exec = 1'b1; step(); first_exec = 1'b0;
  endtask

  task automatic enter(input int p, input int n);
    raise(p, n); step(); pend_valid = 1'b0;
    finish_entry();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 stack_req", int'(stack_req), 0);
    chk("R11 unstack_req", int'(unstack_req), 0);
    chk("R11 vec_req", int'(vec_req), 0);
    chk("R11 handler_start", int'(handler_start), 0);
    chk("R11 exec_prio", int'(exec_prio), 16);
    chk("R11 nest_depth", int'(nest_depth), 0);
    chk("R11 ovf_err", int'(ovf_err), 0);
  endtask

  task automatic t_entry();
    do_reset();
    raise(7, 10); step();
    chk("R2 stack_req", int'(stack_req), 1);
    chk("R2 vec_req", int'(vec_req), 1);
    chk("R2 vec_num", int'(vec_num), 10);
    chk("R4 vec_sys low base", int'(vec_sys), 0);
    pend_valid = 1'b0; step();
    chk("R2 vec_req pulse", int'(vec_req), 0);
    first_exec = 1'b1; step(); first_exec = 1'b0;
    chk("R3 no start before stack/vector", int'(handler_start), 0);
    finish_entry();
    chk("R3 handler_start", int'(handler_start), 1);
    chk("R3 exec_prio", int'(exec_prio), 7);
    chk("R10 depth one", int'(nest_depth), 1);
    step();
    chk("R3 start pulse", int'(handler_start), 0);
    raise(7, 11); step(); step();
    chk("R1 tie no preempt", int'(stack_req), 0);
    pend_valid = 1'b0;
    handler_done = 1'b1; step(); handler_done = 1'b0;
    chk("R8 unstack_req", int'(unstack_req), 1);
    chk("R8 no vec_req", int'(vec_req), 0);
    step();
    chk("R8 unstack held", int'(unstack_req), 1);
    unstack_done = 1'b1; step(); unstack_done = 1'b0;
    chk("R8 ret_to_thread", int'(ret_to_thread), 1);
    chk("R8 exec thread", int'(exec_prio), 16);
    chk("R10 depth zero", int'(nest_depth), 0);
  endtask

  task automatic t_path();
    do_reset();
    vtab_base = 32'h2000_0000;
    raise(3, 5); step();
    chk("R4 vec_sys at limit", int'(vec_sys), 1);
    vtab_base = 32'h1FFF_FFFF;
    raise(1, 6); step();
    chk("R5 late vec_req", int'(vec_req), 1);
    chk("R4 vec_sys below limit", int'(vec_sys), 0);
    chk("R5 late vec_num", int'(vec_num), 6);
    pend_valid = 1'b0;
  endtask

  task automatic t_late();
    do_reset();
    raise(10, 4); step();
    raise(10, 9); step();
    chk("R5 tie no replace", int'(vec_req), 0);
    chk("R5 tie keeps num", int'(vec_num), 4);
    raise(6, 9); step();
    chk("R5 replace vec_req", int'(vec_req), 1);
    chk("R5 replace num", int'(vec_num), 9);
    chk("R5 stacking kept", int'(stack_req), 1);
    pend_valid = 1'b0;
    vec_done = 1'b1; step(); vec_done = 1'b0;
    stack_done = 1'b1; step(); stack_done = 1'b0;
    raise(3, 12); step();
    chk("R5 replace after stacking", int'(vec_req), 1);
    chk("R5 replace num 12", int'(vec_num), 12);
    chk("R5 no restack", int'(stack_req), 0);
    pend_valid = 1'b0;
    first_exec = 1'b1; step(); first_exec = 1'b0;
    chk("R3 waits for new vector", int'(handler_start), 0);
    vec_done = 1'b1; step(); vec_done = 1'b0;
    first_exec = 1'b1; step(); first_exec = 1'b0;
    chk("R3 start after refetch", int'(handler_start), 1);
    chk("R5 exec late prio", int'(exec_prio), 3);
  endtask

  task automatic t_same_cycle();
    do_reset();
    raise(8, 3); step(); pend_valid = 1'b0;
    vec_done = 1'b1; step(); vec_done = 1'b0;
    stack_done = 1'b1; step(); stack_done = 1'b0;
    raise(2, 7); first_exec = 1'b1; step(); first_exec = 1'b0;
    chk("R6 start wins", int'(handler_start), 1);
    chk("R6 old prio", int'(exec_prio), 8);
    chk("R6 no fetch same cycle", int'(vec_req), 0);
    step();
    chk("R6 then preempts", int'(stack_req), 1);
    chk("R6 fetch new", int'(vec_req), 1);
    chk("R6 new num", int'(vec_num), 7);
    pend_valid = 1'b0;
    finish_entry();
    chk("R6 nested prio", int'(exec_prio), 2);
    chk("R10 nested depth", int'(nest_depth), 2);
  endtask

  task automatic t_chain();
    do_reset();
    enter(9, 1);
    raise(12, 2); step();
    chk("R1 less urgent waits", int'(stack_req), 0);
    handler_done = 1'b1; step(); handler_done = 1'b0;
    chk("R7 no unstack", int'(unstack_req), 0);
    chk("R7 no stacking", int'(stack_req), 0);
    chk("R7 vec_req", int'(vec_req), 1);
    chk("R7 vec_num", int'(vec_num), 2);
    pend_valid = 1'b0;
    vec_done = 1'b1; step(); vec_done = 1'b0;
    first_exec = 1'b1; step(); first_exec = 1'b0;
    chk("R7 start", int'(handler_start), 1);
    chk("R7 prio", int'(exec_prio), 12);
    chk("R7 depth kept", int'(nest_depth), 1);
    enter(4, 3);
    raise(13, 6); step();
    handler_done = 1'b1; step(); handler_done = 1'b0;
    chk("R8 pending not above ctx", int'(unstack_req), 1);
    unstack_done = 1'b1; step(); unstack_done = 1'b0;
    chk("R8 ret_to_handler", int'(ret_to_handler), 1);
    chk("R8 exec restored", int'(exec_prio), 12);
    chk("R10 depth after pop", int'(nest_depth), 1);
    pend_valid = 1'b0;
  endtask

  task automatic t_abandon();
    do_reset();
    enter(5, 1);
    enter(2, 2);
    handler_done = 1'b1; step(); handler_done = 1'b0;
    chk("R8 unstacking", int'(unstack_req), 1);
    chk("R8 ctx prio", int'(exec_prio), 5);
    raise(5, 9); step();
    chk("R9 tie keeps restore", int'(unstack_req), 1);
    chk("R9 tie no fetch", int'(vec_req), 0);
    raise(4, 9); step();
    chk("R9 restore dropped", int'(unstack_req), 0);
    chk("R9 fetch", int'(vec_req), 1);
    chk("R9 num", int'(vec_num), 9);
    chk("R9 no stacking", int'(stack_req), 0);
    pend_valid = 1'b0;
    vec_done = 1'b1; step(); vec_done = 1'b0;
    first_exec = 1'b1; step(); first_exec = 1'b0;
    chk("R9 chained start", int'(handler_start), 1);
    chk("R9 prio", int'(exec_prio), 4);
    chk("R9 depth", int'(nest_depth), 2);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 8; i++) enter(14 - i, i);
    chk("R10 full depth", int'(nest_depth), 8);
    chk("R10 no ovf yet", int'(ovf_err), 0);
    enter(6, 8);
    chk("R10 ovf set", int'(ovf_err), 1);
    chk("R10 depth capped", int'(nest_depth), 8);
    handler_done = 1'b1; step(); handler_done = 1'b0;
    unstack_done = 1'b1; step(); unstack_done = 1'b0;
    chk("R10 ovf sticky", int'(ovf_err), 1);
    chk("R10 depth popped", int'(nest_depth), 7);
    do_reset();
    chk("R11 ovf cleared", int'(ovf_err), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_entry();
    t_path();
    t_late();
    t_same_cycle();
    t_chain();
    t_abandon();
    t_overflow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule